// File: doc/BRIEF.md
# Limit-Compare Interval Timer

A memory-mapped interval timer with four word-indexed registers and one level interrupt. A count field advances by one unit on each pulse of a single-cycle tick enable (a 500 ns strobe made elsewhere). The field is placed at bit `LSB` of the register word, so every bit below it reads as zero. The most significant bit of the counter word is a sticky reached flag.

When a tick brings the count to the terminal value, the block sets the reached flag and raises `irq`. The next tick returns the count to zero, and counting continues. The terminal value is the programmed limit. A limit of zero selects the full range of the field, so the counter then runs free.

Software programs the limit through one of two addresses. Writing index 0 also restarts the count and drops the interrupt. Writing index 2 swaps the limit without disturbing the count. Reading index 0 returns the limit and acknowledges the interrupt.

Top module: `lim_timer`

## Requirements
- R1: Each cycle with `tick` high adds one unit at bit `LSB` of the count. The count does not change in a cycle without `tick` or a register write.
- R2: Reading index 1 returns the count in bits `LSB+CNT_W-1:LSB` and the reached flag in bit 31. All other bits are zero.
- R3: Writing index 0 stores `wdata[LSB+CNT_W-1:LSB]` as the limit and ignores all other data bits. The same write clears the count to zero and drives `irq` low.
- R4: Writing index 2 stores the limit with the same masking as R3. The count is left unchanged.
- R5: A tick that moves the count onto the terminal value sets the reached flag and raises `irq`. A tick taken while the count is at the terminal value returns the count to zero.
- R6: A stored limit of zero makes the terminal value the all-ones count field (free run).
- R7: Reading index 0 returns the stored limit at its field position and clears both the reached flag and `irq`. If a reach event occurs in the same cycle, the reach event wins.
- R8: Once raised, `irq` stays high until it is acknowledged by a read of index 0 or a write to index 0.
- R9: Reading index 3 returns `irq` in bit 0 and the reached flag in bit 1, with all other bits zero. This read has no side effect.
- R10: Writes to index 1 and index 3 have no effect.
- R11: Reading index 2 returns zero.
- R12: After reset, the limit, the count, the reached flag and `irq` are all zero, and the counter runs free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle count enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (carries the index 0 side effects) |
| addr | input | 2 | Word index of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational from `addr` |
| irq | output | 1 | Level interrupt |

## Verification
The hardest events to reach from the ports are the full-range wrap in free-run mode and a limit lowered below the running count. With the default width, either one takes millions of ticks. The bench therefore builds the block with a five-bit count field. It then sweeps every limit, including zero, and follows each limit through its reach and its wrap. A separate step drives a reach tick and an acknowledge read in the same cycle, so that the precedence rule of R7 is exercised directly.

// File: rtl/lim_timer.sv
module lim_timer #(
  parameter int DATA_W = 32,
  parameter int LSB    = 9,
  parameter int CNT_W  = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam logic [CNT_W-1:0] FULL = '1;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam int PAD = DATA_W - CNT_W;

  logic [CNT_W-1:0] cnt, lim;
  logic             reached;

  wire [CNT_W-1:0] term    = (lim == '0) ? FULL : lim;
  wire [CNT_W-1:0] cnt_inc = cnt + ONE;
  wire             at_term = (cnt == term);
  wire             reach   = tick && !at_term && (cnt_inc == term);
  wire             wr_lim  = wr_en && (addr == 2'd0);
  wire             wr_nr   = wr_en && (addr == 2'd2);
  wire             ack     = rd_en && (addr == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      lim     <= '0;
      reached <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (wr_lim || wr_nr)
        lim <= wdata[LSB +: CNT_W];

      if (wr_lim)
        cnt <= '0;
      else if (tick)
        cnt <= at_term ? '0 : cnt_inc;

      if (reach && !wr_lim) begin
        reached <= 1'b1;
        irq     <= 1'b1;
      end else begin
        if (ack)
          reached <= 1'b0;
        if (ack || wr_lim)
          irq <= 1'b0;
      end
    end
  end

  wire [DATA_W-1:0] cnt_word = {{PAD{1'b0}}, cnt} << LSB;
  wire [DATA_W-1:0] lim_word = {{PAD{1'b0}}, lim} << LSB;

  always_comb begin
    case (addr)
      2'd0:    rdata = lim_word;
      2'd1:    rdata = cnt_word | {reached, {(DATA_W-1){1'b0}}};
      2'd3:    rdata = {{(DATA_W-2){1'b0}}, reached, irq};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/lim_timer_chk.sv
module lim_timer_chk #(
  parameter int DATA_W = 32,
  parameter int LSB    = 9,
  parameter int CNT_W  = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic              rd_en,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  term
);
  wire lim_wr = wr_en && (addr == 2'd0);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !lim_wr) |=> $stable(cnt));

  p_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != 2'd3) |-> (rdata[LSB-1:0] == '0));

  p_limwr_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lim_wr |=> (cnt == '0) && !irq);

  p_norst_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && !tick) |=> $stable(cnt));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == term && !lim_wr) |=> (cnt == '0));

  p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0 && !tick) |=> !irq);

  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(rd_en && addr == 2'd0) && !lim_wr) |=> irq);
endmodule

bind lim_timer lim_timer_chk #(.DATA_W(DATA_W), .LSB(LSB), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .rdata(rdata), .irq(irq), .cnt(cnt), .term(term)
);

// File: tb/tb_lim_timer.sv
module tb_lim_timer;
  localparam int CLK_P = 10;
  localparam int LSB   = 9;
  localparam int CW    = 5;
  localparam int TOP   = (1 << CW) - 1;

  logic        clk = 0, rst_n = 0, tick = 0, wr_en = 0, rd_en = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0, rdata, v;
  logic        irq;
  int          nvec = 0, nbad = 0;
  bit          done = 0;

  always #(CLK_P/2) clk = ~clk;

  lim_timer #(.DATA_W(32), .LSB(LSB), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(); tick = 1; @(negedge clk); tick = 0; endtask
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d; @(negedge clk); wr_en = 0;
  endtask
  task automatic peek(input logic [1:0] a, output logic [31:0] o);
    addr = a; #1; o = rdata;
  endtask
  task automatic ack(output logic [31:0] o);
    addr = 0; rd_en = 1; #1; o = rdata; @(negedge clk); rd_en = 0;
  endtask

  function automatic logic [31:0] cw(input int c, input bit r);
    return (32'(c) << LSB) | (r ? 32'h8000_0000 : 32'h0);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R12 irq", {31'b0, irq}, 0);
    peek(0, v); chk("R12 limit", v, 0);
    peek(1, v); chk("R12 count", v, 0);
    peek(3, v); chk("R12 status", v, 0);
    for (int k = 1; k <= 3; k++) begin
      step(); peek(1, v); chk("R12 free run", v, cw(k, 0));
    end

    for (int L = 0; L <= TOP; L++) begin
      automatic int t = (L == 0) ? TOP : L;
      wr(0, (32'(L) << LSB) | 32'h8001_C1FF);
      peek(1, v); chk("R3 count cleared", v, 0);
      chk("R3 irq low", {31'b0, irq}, 0);
      ack(v); chk("R7 limit readback", v, 32'(L) << LSB);
      for (int k = 1; k <= t; k++) begin
        step(); peek(1, v);
        chk(L == 0 ? "R6 free-run count" : "R1 R5 count", v, cw(k, k == t));
      end
      chk("R5 irq raised", {31'b0, irq}, 1);
      step(); peek(1, v); chk("R5 wrap to zero", v, cw(0, 1));
      step(); peek(1, v); chk("R8 count after wrap", v, cw(1, 1));
      chk("R8 irq held", {31'b0, irq}, 1);
      peek(3, v); chk("R9 status", v, 3);
      peek(3, v); chk("R9 no side effect", v, 3);
      ack(v); chk("R7 ack read", v, 32'(L) << LSB);
      chk("R7 irq cleared", {31'b0, irq}, 0);
      peek(3, v); chk("R7 reached cleared", v, 0);
    end

    wr(0, 32'(10) << LSB);
    repeat (3) step();
    wr(2, 32'(20) << LSB);
    peek(1, v); chk("R4 count kept", v, cw(3, 0));
    ack(v); chk("R4 limit stored", v, 32'(20) << LSB);
    repeat (17) step();
    peek(1, v); chk("R4 reach at new limit", v, cw(20, 1));
    ack(v);
    wr(2, 32'(2) << LSB);
    repeat (11) step();
    peek(1, v); chk("R4 runs past lower limit", v, cw(TOP, 0));
    step(); peek(1, v); chk("R4 natural wrap", v, cw(0, 0));
    repeat (2) step();
    peek(1, v); chk("R4 R5 reach after wrap", v, cw(2, 1));
    ack(v);

    wr(1, 32'hFFFF_FFFF);
    wr(3, 32'hFFFF_FFFF);
    peek(1, v); chk("R10 count untouched", v, cw(2, 0));
    peek(3, v); chk("R10 status untouched", v, 0);
    ack(v); chk("R10 limit untouched", v, 32'(2) << LSB);
    peek(2, v); chk("R11 index 2 reads zero", v, 0);

    wr(0, 32'(4) << LSB);
    repeat (3) step();
    tick = 1; rd_en = 1; addr = 0; @(negedge clk); tick = 0; rd_en = 0;
    chk("R7 reach beats ack", {31'b0, irq}, 1);
    peek(1, v); chk("R7 reached kept", v, cw(4, 1));

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule